// File: doc/BRIEF.md
# Grouped Interrupt Cause Register Bank

This block collects interrupt events from three groups (transmit, receive and miscellaneous) into sticky 32-bit cause registers. Software reaches them through a simple word-addressed register port. Each group has a mask that is changed by separate set and clear write locations, read-only views of the mask and of the masked cause, and a mode register. The mode register selects how the group's cause bits are acknowledged: by writing ones, or simply by reading the register.

A three-bit summary register records which groups hold an unmasked pending cause. Reading the summary clears it. The summary has its own mask, and the registered interrupt output is raised when an unmasked summary bit is set. The address is five bits wide. Bits [4:3] pick a slot: 0 transmit, 1 receive, 2 miscellaneous, 3 summary. Bits [2:0] pick the register within that slot. In a group slot the registers are: 0 cause, 1 mask-set, 2 mask-clear, 3 mask view, 4 masked-cause view, 5 mode. In the summary slot they are: 0 summary, 1 summary mask.

Top module: `evt_cause_hub`

## Requirements
- R1: A synchronous reset clears every cause bit and the summary to zero, sets every group mask bit and all three summary mask bits to one, selects write-one-to-clear mode in every group, and drives the interrupt output, the read-valid output and the read data to zero.
- R2: An event bit raised at a group input sets the matching cause bit at the next clock edge. The bit stays set until it is acknowledged. An event that arrives in the same cycle as an acknowledge of that bit leaves the bit set.
- R3: In write-one-to-clear mode, writing the cause register (offset 0) clears each bit written as one and leaves bits written as zero unchanged. Reading the cause register does not change it.
- R4: Writing all ones to the mode register (offset 5) selects clear-on-read mode, and the register then reads back all ones. In that mode a read of the cause register returns its value and clears it, and writes to the cause register are ignored. Writing any other value selects write-one-to-clear mode, and the register then reads back zero.
- R5: Writing offset 1 sets each mask bit written as one. Writing offset 2 clears each mask bit written as one. Offset 3 reads the mask, where a one means the bit is masked.
- R6: Offset 4 reads the cause register ANDed with the inverted mask.
- R7: Summary bit 0 is transmit, bit 1 is receive and bit 2 is miscellaneous. A summary bit is set one clock after its group has a nonzero masked cause, and it stays set after that. A read of summary offset 0 returns the summary and clears it, but a group that is still active sets its bit again in the same edge. Writes to the summary are ignored.
- R8: Summary offset 1 holds the summary mask. A one blocks that summary bit, and a write stores write-data bits [2:0]. The interrupt output is a register that goes high one clock after any summary bit is set while its summary mask bit is zero.
- R9: A read request is answered one clock later with the read-valid output high and the register value on the read data. Reads of write-only or unused locations return zero. In a cycle that follows no read request, read-valid and read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_i | input | 32 | Transmit group event bits |
| ev_rx_i | input | 32 | Receive group event bits |
| ev_misc_i | input | 32 | Miscellaneous group event bits |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 5 | Word address: slot in [4:3], register in [2:0] |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| reg_rvalid_o | output | 1 | Read data valid, one clock after the read strobe |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The transmit group is exercised in write-one-to-clear mode. Its patterns include partial acknowledges, repeated reads and an event that arrives in the same cycle as its own acknowledge; together they show whether clearing is selective and whether it can lose a new event. The receive group is switched to clear-on-read mode and then back again with a value that is not all ones. This shows the difference between the mode's effect on reads and its effect on writes, and how the mode value is decoded. The miscellaneous group and the summary mask are used to separate the case "pending but blocked" from the case "pending and signalled". Repeated summary reads while a source is still active show that such a read does not drop a live group. A behavioural model checks every output on every clock, alongside directed readbacks whose values are worked out by hand.

// File: rtl/ech_pkg.sv
package ech_pkg;
  // Number of cause groups and their slot numbers
  localparam int NUM_GRP  = 3;
  localparam int GRP_TX   = 0;
  localparam int GRP_RX   = 1;
  localparam int GRP_MISC = 2;

  // Address split: slot field above, register offset below
  localparam int OFS_W  = 3;
  localparam int SLOT_W = 2;
  localparam int ADDR_W = SLOT_W + OFS_W;

  localparam logic [SLOT_W-1:0] SLOT_SUMMARY = 2'd3;

  // Register offsets inside a group slot
  localparam logic [OFS_W-1:0] OFS_CAUSE  = 3'd0;
  localparam logic [OFS_W-1:0] OFS_MSET   = 3'd1;
  localparam logic [OFS_W-1:0] OFS_MCLR   = 3'd2;
  localparam logic [OFS_W-1:0] OFS_MVAL   = 3'd3;
  localparam logic [OFS_W-1:0] OFS_MCAUSE = 3'd4;
  localparam logic [OFS_W-1:0] OFS_MODE   = 3'd5;

  // Register offsets inside the summary slot
  localparam logic [OFS_W-1:0] OFS_SUMM   = 3'd0;
  localparam logic [OFS_W-1:0] OFS_SMASK  = 3'd1;
endpackage

// File: rtl/ech_group.sv
module ech_group
  import ech_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    ev_i,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [DW-1:0]    cause_o,
  output logic [DW-1:0]    mask_o,
  output logic             active_o
);
  logic [DW-1:0] cause_q;
  logic [DW-1:0] mask_q;
  logic          cor_q;    // 1: clear-on-read, 0: write-one-to-clear
  logic [DW-1:0] clr;
  logic          wr_hit;
  logic          rd_hit;

  assign wr_hit = sel_i & wr_i;
  assign rd_hit = sel_i & rd_i;

  // Acknowledge vector: the source depends on the clear mode
  always_comb begin
    clr = '0;
    if (ofs_i == OFS_CAUSE) begin
      if (!cor_q && wr_hit) clr = wdata_i;
      if (cor_q && rd_hit)  clr = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mask_q  <= '1;
      cor_q   <= 1'b0;
    end else begin
      // New events win over a simultaneous acknowledge
      cause_q <= (cause_q & ~clr) | ev_i;
      if (wr_hit && ofs_i == OFS_MSET)
        mask_q <= mask_q | wdata_i;
      else if (wr_hit && ofs_i == OFS_MCLR)
        mask_q <= mask_q & ~wdata_i;
      if (wr_hit && ofs_i == OFS_MODE)
        cor_q <= &wdata_i;
    end
  end

  always_comb begin
    case (ofs_i)
      OFS_CAUSE:  rdata_o = cause_q;
      OFS_MVAL:   rdata_o = mask_q;
      OFS_MCAUSE: rdata_o = cause_q & ~mask_q;
      OFS_MODE:   rdata_o = {DW{cor_q}};
      default:    rdata_o = '0;
    endcase
  end

  assign cause_o  = cause_q;
  assign mask_o   = mask_q;
  assign active_o = |(cause_q & ~mask_q);
endmodule

// File: rtl/ech_summary.sv
module ech_summary
  import ech_pkg::*;
#(
  parameter int DW = 32,
  parameter int NG = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NG-1:0]    active_i,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [NG-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [NG-1:0]    summ_o,
  output logic [NG-1:0]    smask_o,
  output logic             irq_o
);
  logic [NG-1:0] summ_q;
  logic [NG-1:0] smask_q;
  logic          irq_q;
  logic          rd_clr;

  assign rd_clr = sel_i & rd_i & (ofs_i == OFS_SUMM);

  always_ff @(posedge clk) begin
    if (rst) begin
      summ_q  <= '0;
      smask_q <= '1;
      irq_q   <= 1'b0;
    end else begin
      // A read clears the summary, but a live group sets its bit again
      summ_q <= (rd_clr ? '0 : summ_q) | active_i;
      if (sel_i && wr_i && ofs_i == OFS_SMASK)
        smask_q <= wdata_i;
      irq_q <= |(summ_q & ~smask_q);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ofs_i == OFS_SUMM)
      rdata_o[NG-1:0] = summ_q;
    else if (ofs_i == OFS_SMASK)
      rdata_o[NG-1:0] = smask_q;
  end

  assign summ_o  = summ_q;
  assign smask_o = smask_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/evt_cause_hub.sv
module evt_cause_hub
  import ech_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW-1:0]     ev_tx_i,
  input  logic [DW-1:0]     ev_rx_i,
  input  logic [DW-1:0]     ev_misc_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              reg_rvalid_o,
  output logic              irq_o
);
  localparam int NG = NUM_GRP;

  logic [SLOT_W-1:0]       slot;
  logic [OFS_W-1:0]        ofs;
  logic [NG-1:0][DW-1:0]   ev_all;
  logic [NG-1:0][DW-1:0]   grp_rdata;
  logic [NG-1:0][DW-1:0]   cause_all;
  logic [NG-1:0][DW-1:0]   mask_all;
  logic [NG-1:0]           active;
  logic [NG-1:0]           summ;
  logic [NG-1:0]           smask;
  logic [DW-1:0]           sum_rdata;
  logic [DW-1:0]           rd_mux;
  logic [DW-1:0]           rdata_q;
  logic                    rvalid_q;

  assign slot = reg_addr_i[ADDR_W-1:OFS_W];
  assign ofs  = reg_addr_i[OFS_W-1:0];

  assign ev_all[GRP_TX]   = ev_tx_i;
  assign ev_all[GRP_RX]   = ev_rx_i;
  assign ev_all[GRP_MISC] = ev_misc_i;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    ech_group #(.DW(DW)) u_grp (
      .clk      (clk),
      .rst      (rst),
      .ev_i     (ev_all[g]),
      .sel_i    (slot == SLOT_W'(g)),
      .wr_i     (reg_wr_i),
      .rd_i     (reg_rd_i),
      .ofs_i    (ofs),
      .wdata_i  (reg_wdata_i),
      .rdata_o  (grp_rdata[g]),
      .cause_o  (cause_all[g]),
      .mask_o   (mask_all[g]),
      .active_o (active[g])
    );
  end

  ech_summary #(.DW(DW), .NG(NG)) u_sum (
    .clk      (clk),
    .rst      (rst),
    .active_i (active),
    .sel_i    (slot == SLOT_SUMMARY),
    .wr_i     (reg_wr_i),
    .rd_i     (reg_rd_i),
    .ofs_i    (ofs),
    .wdata_i  (reg_wdata_i[NG-1:0]),
    .rdata_o  (sum_rdata),
    .summ_o   (summ),
    .smask_o  (smask),
    .irq_o    (irq_o)
  );

  // Read mux over the slots; the result is registered
  always_comb begin
    rd_mux = '0;
    if (slot == SLOT_SUMMARY) rd_mux = sum_rdata;
    for (int g = 0; g < NG; g++)
      if (slot == SLOT_W'(g)) rd_mux = grp_rdata[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= reg_rd_i ? rd_mux : '0;
      rvalid_q <= reg_rd_i;
    end
  end

  assign reg_rdata_o  = rdata_q;
  assign reg_rvalid_o = rvalid_q;
endmodule

// File: rtl/ech_chk.sv
module ech_chk
  import ech_pkg::*;
#(
  parameter int DW = 32,
  parameter int NG = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DW-1:0]     reg_wdata_i,
  input logic [DW-1:0]     ev_tx_i,
  input logic [DW-1:0]     reg_rdata_o,
  input logic              reg_rvalid_o,
  input logic              irq_o,
  input logic [DW-1:0]     cause_tx,
  input logic [DW-1:0]     mask_tx,
  input logic [NG-1:0]     summ,
  input logic [NG-1:0]     smask
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!irq_o && !reg_rvalid_o && mask_tx == '1 && summ == '0 && cause_tx == '0));

  // R2
  event_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_tx_i != '0) |=> ((cause_tx & $past(ev_tx_i)) == $past(ev_tx_i)));

  // R5
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_addr_i == 5'd1) |=> ((mask_tx & $past(reg_wdata_i)) == $past(reg_wdata_i)));

  // R7
  summary_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (|(cause_tx & ~mask_tx)) |=> summ[0]);

  // R8
  irq_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (smask == '1) |=> !irq_o);

  // R9
  rvalid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd_i |=> reg_rvalid_o);

  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_i |=> (!reg_rvalid_o && reg_rdata_o == '0));
endmodule

bind evt_cause_hub ech_chk #(.DW(DW), .NG(NG)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_wr_i     (reg_wr_i),
  .reg_rd_i     (reg_rd_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .ev_tx_i      (ev_tx_i),
  .reg_rdata_o  (reg_rdata_o),
  .reg_rvalid_o (reg_rvalid_o),
  .irq_o        (irq_o),
  .cause_tx     (cause_all[0]),
  .mask_tx      (mask_all[0]),
  .summ         (summ),
  .smask        (smask)
);

// File: tb/sim_evt_cause_hub.sv
module sim_evt_cause_hub;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] ev_tx = '0, ev_rx = '0, ev_misc = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [4:0]    addr = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rdata;
  logic          rvalid, irq;

  int    total = 0;
  int    bad   = 0;
  bit    done  = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  evt_cause_hub #(.DW(DW)) u0 (
    .clk(clk), .rst(rst),
    .ev_tx_i(ev_tx), .ev_rx_i(ev_rx), .ev_misc_i(ev_misc),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .reg_rvalid_o(rvalid), .irq_o(irq)
  );

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [DW-1:0] mc [3];
  logic [DW-1:0] mm [3];
  bit            mcor [3];
  logic [2:0]    ms, msm;
  logic          mirq, mrv;
  logic [DW-1:0] mrd;

  always @(posedge clk) begin
    logic [DW-1:0] rv, clr, nm;
    logic [DW-1:0] evv [3];
    logic [2:0]    act;
    logic          nirq;
    int            sl, of;
    if (rst) begin
      for (int g = 0; g < 3; g++) begin mc[g] = '0; mm[g] = '1; mcor[g] = 0; end
      ms = '0; msm = 3'b111; mirq = 0; mrv = 0; mrd = '0;
    end else begin
      sl = int'(addr[4:3]); of = int'(addr[2:0]);
      evv[0] = ev_tx; evv[1] = ev_rx; evv[2] = ev_misc;
      rv = '0;
      if (sl == 3) begin
        if (of == 0) rv = {29'b0, ms};
        else if (of == 1) rv = {29'b0, msm};
      end else begin
        case (of)
          0: rv = mc[sl];
          3: rv = mm[sl];
          4: rv = mc[sl] & ~mm[sl];
          5: rv = mcor[sl] ? '1 : '0;
          default: rv = '0;
        endcase
      end
      nirq = |(ms & ~msm);
      for (int g = 0; g < 3; g++) act[g] = |(mc[g] & ~mm[g]);
      for (int g = 0; g < 3; g++) begin
        clr = '0;
        if (sl == g && of == 0) begin
          if (!mcor[g] && wr) clr = wd;
          if (mcor[g] && rd)  clr = '1;
        end
        nm = mm[g];
        if (wr && sl == g && of == 1) nm = nm | wd;
        if (wr && sl == g && of == 2) nm = nm & ~wd;
        if (wr && sl == g && of == 5) mcor[g] = (wd == 32'hFFFF_FFFF);
        mc[g] = (mc[g] & ~clr) | evv[g];
        mm[g] = nm;
      end
      if (rd && sl == 3 && of == 0) ms = act; else ms = ms | act;
      if (wr && sl == 3 && of == 1) msm = wd[2:0];
      mirq = nirq; mrv = rd; mrd = rd ? rv : '0;
    end
  end

  // Compare all outputs against the model away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cur_req, "model irq",    {31'b0, irq},    {31'b0, mirq});
      check(cur_req, "model rvalid", {31'b0, rvalid}, {31'b0, mrv});
      check(cur_req, "model rdata",  rdata,           mrd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_write(logic [4:0] a, logic [DW-1:0] d);
    @(negedge clk); wr = 1; addr = a; wd = d;
    @(negedge clk); wr = 0; wd = '0;
  endtask

  task automatic do_read(logic [4:0] a, output logic [DW-1:0] v);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; v = rdata;
    check("R9", "rvalid on answer", {31'b0, rvalid}, 32'd1);
  endtask

  task automatic expect_rd(string req, logic [4:0] a, logic [DW-1:0] exp);
    logic [DW-1:0] v;
    do_read(a, v);
    check(req, $sformatf("read addr %0d", a), v, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    cur_req = "R1";
    check("R1", "irq after reset", {31'b0, irq}, 32'd0);
    expect_rd("R1", 5'd3,  32'hFFFF_FFFF);
    expect_rd("R1", 5'd5,  32'h0);
    expect_rd("R1", 5'd25, 32'h7);
    expect_rd("R1", 5'd0,  32'h0);

    // R2 sticky events, R3 reads do not clear in write-one-to-clear mode
    cur_req = "R2";
    @(negedge clk); ev_tx = 32'hA5; @(negedge clk); ev_tx = '0;
    expect_rd("R2", 5'd0, 32'hA5);
    cur_req = "R3";
    expect_rd("R3", 5'd0, 32'hA5);
    do_write(5'd0, 32'h05);
    expect_rd("R3", 5'd0, 32'hA0);

    // R2 event in the same cycle as its acknowledge stays set
    cur_req = "R2";
    @(negedge clk); wr = 1; addr = 5'd0; wd = 32'h80; ev_tx = 32'h80;
    @(negedge clk); wr = 0; wd = '0; ev_tx = '0;
    expect_rd("R2", 5'd0, 32'hA0);

    // R5 / R6 masking and views
    cur_req = "R6";
    expect_rd("R6", 5'd4, 32'h0);
    cur_req = "R5";
    do_write(5'd2, 32'h20);
    expect_rd("R5", 5'd3, 32'hFFFF_FFDF);
    cur_req = "R6";
    expect_rd("R6", 5'd4, 32'h20);

    // R8 blocked by summary mask, R7 summary bit 0
    cur_req = "R8";
    idle(2);
    check("R8", "irq blocked by summary mask", {31'b0, irq}, 32'd0);
    cur_req = "R7";
    expect_rd("R7", 5'd24, 32'h1);
    cur_req = "R8";
    do_write(5'd25, 32'h0);
    idle(2);
    check("R8", "irq raised when unmasked", {31'b0, irq}, 32'd1);

    // R7 summary sticky after source clears, cleared by read
    cur_req = "R7";
    do_write(5'd0, 32'hA0);
    idle(2);
    check("R7", "irq held by sticky summary", {31'b0, irq}, 32'd1);
    expect_rd("R7", 5'd24, 32'h1);
    idle(2);
    check("R7", "irq after summary read", {31'b0, irq}, 32'd0);
    expect_rd("R7", 5'd24, 32'h0);

    // R4 clear-on-read in the receive group
    cur_req = "R4";
    do_write(5'd13, 32'hFFFF_FFFF);
    expect_rd("R4", 5'd13, 32'hFFFF_FFFF);
    @(negedge clk); ev_rx = 32'h3C; @(negedge clk); ev_rx = '0;
    do_write(5'd8, 32'h3C);
    expect_rd("R4", 5'd8, 32'h3C);
    expect_rd("R4", 5'd8, 32'h0);
    do_write(5'd13, 32'h0000_FFFF);
    expect_rd("R4", 5'd13, 32'h0);
    @(negedge clk); ev_rx = 32'h1; @(negedge clk); ev_rx = '0;
    expect_rd("R4", 5'd8, 32'h1);
    expect_rd("R4", 5'd8, 32'h1);

    // R8 / R7 miscellaneous group and summary mask bit 2
    cur_req = "R8";
    do_write(5'd18, 32'h1);
    @(negedge clk); ev_misc = 32'h1; @(negedge clk); ev_misc = '0;
    idle(2);
    check("R8", "irq from misc group", {31'b0, irq}, 32'd1);
    do_write(5'd25, 32'h4);
    idle(2);
    check("R8", "irq blocked for misc", {31'b0, irq}, 32'd0);
    cur_req = "R7";
    expect_rd("R7", 5'd24, 32'h4);
    expect_rd("R7", 5'd24, 32'h4);

    // R9 write-only and unused locations
    cur_req = "R9";
    expect_rd("R9", 5'd6,  32'h0);
    expect_rd("R9", 5'd1,  32'h0);
    expect_rd("R9", 5'd26, 32'h0);
    idle(1);
    check("R9", "rvalid idle", {31'b0, rvalid}, 32'd0);

    // R5 mask set
    cur_req = "R5";
    do_write(5'd1, 32'h20);
    expect_rd("R5", 5'd3, 32'hFFFF_FFFF);

    idle(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule